// File: doc/BRIEF.md
# Serial Command Bus Register Slave

This block is the register front end of an inband tone signalling subsystem. A host microcontroller talks to it over a five-wire serial bus: a serial clock, a command data line, a reply data line, an active-low chip select and an open-drain, active-low interrupt. The block samples all bus pins with its own system clock. After chip select falls, the first byte is an address/command byte. That byte fixes how many data bytes follow and whether they are written to the block or read back from it. Every byte takes effect as soon as its eighth bit arrives. Raising chip select ends a transfer, or aborts it part way through.

The block holds a control register and the tone, notone-period and interval-timer words, and it hands these to the tone generators and timers next to it. It takes their completion events back into a status register. When an enabled status condition is set, it pulls the interrupt line low. A status read returns the flags, clears them and releases the interrupt. A general reset command returns all of the block's state to zero.

The state machine has five states. ST_IDLE waits for chip select to fall and then moves to ST_ADDR. ST_ADDR collects the command byte and moves to ST_WDATA for a write, to ST_RDATA for a read, or to ST_DISCARD for general reset or an unrecognised code. ST_WDATA and ST_RDATA each move to ST_DISCARD once the last byte of the command has completed. ST_DISCARD ignores all further bits. A high chip select forces every state back to ST_IDLE.

Top module: `tone_bus_slave`

## Requirements
- R1: A transfer starts when chip select is low. Bits are taken MSB first on rising serial-clock edges, and the first byte is the command byte. A serial-clock edge takes effect SYNC_DEPTH+1 system clock cycles after it arrives on the pin.
- R2: Commands 30h (control), 33h (notone period) and 36h (interval timer) take one data byte. Commands 34h and 35h (tone words 1 and 2) take two bytes, with the first byte forming bits 15:8. A word changes only when the final byte of its command completes. Each of notone_wr, timer_wr, tone1_wr and tone2_wr pulses for exactly one cycle per write, at most one at a time.
- R3: The control word keeps bits 7:2 as written, and bits 1:0 always read 0. Bit 7 is the audio switch, bit 6 enables the interval-timer interrupt, bit 5 enables the decoder interrupt, bit 4 is the summing switch, and bits 3:2 select the band.
- R4: Command 31h replies with one byte: bit 0 measurement complete, bit 1 notone expired, bit 2 interval timer expired, bit 3 the live logic input, and bits 7:4 zero.
- R5: Command 32h replies with two bytes, bits 15:8 first, of the received-tone word as captured when the command byte completes.
- R6: reply_en is high only while reply bits are being shifted out. It is low during writes, after the last reply byte, and once chip select has been high for SYNC_DEPTH+1 cycles.
- R7: The three event inputs set status bits 0, 1 and 2 whatever the enables are. Recognising 31h clears those bits after they have been captured for the reply. An event in the same cycle as the clear stays set.
- R8: A completed notone write clears status bit 1, and a completed interval-timer write clears status bit 2.
- R9: irq_pull is high exactly when control bit 6 and status bit 2 are both set, or when control bit 5 and status bit 0 or bit 1 are set.
- R10: Command 01h sets the control word, the status bits, both timer words and both tone words to zero, and pulses gen_rst for one cycle.
- R11: After an unrecognised command byte, and after the last byte a command takes, all further bytes are discarded until chip select rises.
- R12: Raising chip select in the middle of a byte, or between the two bytes of a two-byte write, leaves all registers unchanged. The next transfer decodes a fresh command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| cmd_in | input | 1 | Serial command data from the host |
| reply_out | output | 1 | Serial reply bit; meaningful only while reply_en is high |
| reply_en | output | 1 | Reply pad driver enable; low means high impedance |
| irq_pull | output | 1 | Open-drain interrupt: high pulls the shared line low |
| logic_in | input | 1 | General-purpose logic input, reported live in status bit 3 |
| meas_done_evt | input | 1 | One-cycle event: a tone measurement completed |
| notone_evt | input | 1 | One-cycle event: the notone period expired |
| timer_evt | input | 1 | One-cycle event: the interval timer expired |
| rx_tone_word | input | 16 | Measured received-tone word |
| ctrl_reg | output | 8 | Control word |
| notone_word | output | 8 | Notone period word |
| timer_word | output | 8 | Interval timer word |
| tone1_word | output | 16 | Tone generator 1 word |
| tone2_word | output | 16 | Tone generator 2 word |
| notone_wr | output | 1 | One-cycle pulse when notone_word is written |
| timer_wr | output | 1 | One-cycle pulse when timer_word is written |
| tone1_wr | output | 1 | One-cycle pulse when tone1_word is written |
| tone2_wr | output | 1 | One-cycle pulse when tone2_word is written |
| gen_rst | output | 1 | One-cycle pulse on general reset |

## Verification
The bench builds the block with the default SYNC_DEPTH of 2 and holds each serial-clock phase for four system cycles. With that spacing, any synchronizer depth up to three is exercised by the same stimulus. Because the bench knows SYNC_DEPTH, it can fire an event in the exact cycle where a status read clears the flags, and that makes the set-over-clear priority reachable. It can also drop chip select mid-byte and between the bytes of a two-byte write.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 2 * BYTE_W;
    localparam int BIT_CW   = $clog2(BYTE_W);
    localparam int FLAG_N   = 3;

    localparam logic [BYTE_W-1:0] AC_RESET  = 8'h01;
    localparam logic [BYTE_W-1:0] AC_CTRL   = 8'h30;
    localparam logic [BYTE_W-1:0] AC_STATUS = 8'h31;
    localparam logic [BYTE_W-1:0] AC_RXTONE = 8'h32;
    localparam logic [BYTE_W-1:0] AC_NOTONE = 8'h33;
    localparam logic [BYTE_W-1:0] AC_TONE1  = 8'h34;
    localparam logic [BYTE_W-1:0] AC_TONE2  = 8'h35;
    localparam logic [BYTE_W-1:0] AC_TIMER  = 8'h36;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_WDATA, ST_RDATA, ST_DISCARD
    } bus_state_e;

    typedef enum logic [3:0] {
        TGT_NONE, TGT_RESET, TGT_CTRL, TGT_NOTONE, TGT_TIMER,
        TGT_TONE1, TGT_TONE2, TGT_STATUS, TGT_RXTONE
    } bus_tgt_e;

    function automatic bus_tgt_e decode_ac(input logic [BYTE_W-1:0] ac);
        case (ac)
            AC_RESET:  return TGT_RESET;
            AC_CTRL:   return TGT_CTRL;
            AC_STATUS: return TGT_STATUS;
            AC_RXTONE: return TGT_RXTONE;
            AC_NOTONE: return TGT_NOTONE;
            AC_TONE1:  return TGT_TONE1;
            AC_TONE2:  return TGT_TONE2;
            AC_TIMER:  return TGT_TIMER;
            default:   return TGT_NONE;
        endcase
    endfunction

    function automatic logic [1:0] tgt_len(input bus_tgt_e t);
        case (t)
            TGT_CTRL, TGT_NOTONE, TGT_TIMER, TGT_STATUS: return 2'd1;
            TGT_TONE1, TGT_TONE2, TGT_RXTONE:            return 2'd2;
            default:                                     return 2'd0;
        endcase
    endfunction

    function automatic logic tgt_is_read(input bus_tgt_e t);
        return (t == TGT_STATUS) || (t == TGT_RXTONE);
    endfunction

endpackage

// File: rtl/tbs_in_sync.sv
module tbs_in_sync #(
    parameter int          DEPTH   = 2,
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= RST_VAL;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign q = stg[DEPTH-1];

endmodule

// File: rtl/tbs_status.sv
module tbs_status
    import tbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_N-1:0] evt,
    input  logic              rd_clr,
    input  logic              clr_notone,
    input  logic              clr_timer,
    input  logic              wipe,
    output logic [FLAG_N-1:0] flags
);

    logic [FLAG_N-1:0] clr_mask;

    always_comb begin
        clr_mask = {FLAG_N{rd_clr | wipe}};
        clr_mask[1] = clr_mask[1] | clr_notone;
        clr_mask[2] = clr_mask[2] | clr_timer;
    end

    // a new event outranks any clear arriving in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_mask) | evt;
    end

endmodule

// File: rtl/tbs_regs.sv
module tbs_regs
    import tbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  bus_tgt_e          wr_tgt,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wipe,
    output logic [BYTE_W-1:0] ctrl_reg,
    output logic [BYTE_W-1:0] notone_word,
    output logic [BYTE_W-1:0] timer_word,
    output logic [WORD_W-1:0] tone1_word,
    output logic [WORD_W-1:0] tone2_word,
    output logic              notone_wr,
    output logic              timer_wr,
    output logic              tone1_wr,
    output logic              tone2_wr,
    output logic              gen_rst
);

    logic [BYTE_W-1:0] lo_byte;
    assign lo_byte = wr_data[BYTE_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_reg    <= '0;
            notone_word <= '0;
            timer_word  <= '0;
            tone1_word  <= '0;
            tone2_word  <= '0;
            notone_wr   <= 1'b0;
            timer_wr    <= 1'b0;
            tone1_wr    <= 1'b0;
            tone2_wr    <= 1'b0;
            gen_rst     <= 1'b0;
        end else begin
            notone_wr <= 1'b0;
            timer_wr  <= 1'b0;
            tone1_wr  <= 1'b0;
            tone2_wr  <= 1'b0;
            gen_rst   <= wipe;
            if (wipe) begin
                ctrl_reg    <= '0;
                notone_word <= '0;
                timer_word  <= '0;
                tone1_word  <= '0;
                tone2_word  <= '0;
            end else if (wr_stb) begin
                case (wr_tgt)
                    TGT_CTRL:   ctrl_reg <= {lo_byte[BYTE_W-1:2], 2'b00};
                    TGT_NOTONE: begin notone_word <= lo_byte; notone_wr <= 1'b1; end
                    TGT_TIMER:  begin timer_word  <= lo_byte; timer_wr  <= 1'b1; end
                    TGT_TONE1:  begin tone1_word  <= wr_data; tone1_wr  <= 1'b1; end
                    TGT_TONE2:  begin tone2_word  <= wr_data; tone2_wr  <= 1'b1; end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/tone_bus_slave.sv
module tone_bus_slave
    import tbs_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              cmd_in,
    output logic              reply_out,
    output logic              reply_en,
    output logic              irq_pull,
    input  logic              logic_in,
    input  logic              meas_done_evt,
    input  logic              notone_evt,
    input  logic              timer_evt,
    input  logic [15:0]       rx_tone_word,
    output logic [7:0]        ctrl_reg,
    output logic [7:0]        notone_word,
    output logic [7:0]        timer_word,
    output logic [15:0]       tone1_word,
    output logic [15:0]       tone2_word,
    output logic              notone_wr,
    output logic              timer_wr,
    output logic              tone1_wr,
    output logic              tone2_wr,
    output logic              gen_rst
);

    localparam int PIN_N = 4;

    // ---------------- pin sampling ----------------
    logic [PIN_N-1:0] pins_s;
    logic             sclk_s, cs_s, cmd_s, lin_s, sclk_prev;

    tbs_in_sync #(
        .DEPTH   (SYNC_DEPTH),
        .W       (PIN_N),
        .RST_VAL (4'b0010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({logic_in, cmd_in, cs_n, sclk}),
        .q     (pins_s)
    );

    assign {lin_s, cmd_s, cs_s, sclk_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end

    logic rise;
    assign rise = sclk_s & ~sclk_prev & ~cs_s;

    // ---------------- state and datapath registers ----------------
    bus_state_e        state, state_nx;
    bus_tgt_e          tgt, dec;
    logic [BIT_CW-1:0] bit_cnt;
    logic [BYTE_W-1:0] sh_in, sh_out, hi_byte, rd_lo;
    logic [1:0]        left;
    logic [BYTE_W-1:0] in_byte, stat_byte;
    logic              byte_done;
    logic [FLAG_N-1:0] flags, evt_vec;

    assign in_byte   = {sh_in[BYTE_W-2:0], cmd_s};
    assign byte_done = rise && (bit_cnt == BIT_CW'(BYTE_W - 1));
    assign dec       = decode_ac(in_byte);
    assign stat_byte = {{(BYTE_W-FLAG_N-1){1'b0}}, lin_s, flags};
    assign evt_vec   = {timer_evt, notone_evt, meas_done_evt};

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_nx = state;
        if (cs_s) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    state_nx = ST_ADDR;
                ST_ADDR:
                    if (byte_done) begin
                        if (tgt_len(dec) == 2'd0)  state_nx = ST_DISCARD;
                        else if (tgt_is_read(dec)) state_nx = ST_RDATA;
                        else                       state_nx = ST_WDATA;
                    end
                ST_WDATA:   if (byte_done && left == 2'd1) state_nx = ST_DISCARD;
                ST_RDATA:   if (byte_done && left == 2'd1) state_nx = ST_DISCARD;
                ST_DISCARD: state_nx = ST_DISCARD;
            endcase
        end
    end

    // ---------------- state outputs ----------------
    logic              wr_stb, wipe, rd_clr, clr_notone, clr_timer;
    logic [WORD_W-1:0] wr_data;

    always_comb begin
        wr_stb     = 1'b0;
        wipe       = 1'b0;
        rd_clr     = 1'b0;
        reply_en   = 1'b0;
        unique case (state)
            ST_ADDR: begin
                wipe   = byte_done && (dec == TGT_RESET);
                rd_clr = byte_done && (dec == TGT_STATUS);
            end
            ST_WDATA: wr_stb   = byte_done && (left == 2'd1);
            ST_RDATA: reply_en = 1'b1;
            ST_IDLE, ST_DISCARD: ;
        endcase
        wr_data    = {hi_byte, in_byte};
        clr_notone = wr_stb && (tgt == TGT_NOTONE);
        clr_timer  = wr_stb && (tgt == TGT_TIMER);
        reply_out  = reply_en & sh_out[BYTE_W-1];
    end

    // ---------------- shift datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            sh_in   <= '0;
            sh_out  <= '0;
            hi_byte <= '0;
            rd_lo   <= '0;
            left    <= '0;
            tgt     <= TGT_NONE;
        end else if (cs_s) begin
            bit_cnt <= '0;
        end else if (rise) begin
            bit_cnt <= bit_cnt + 1'b1;
            sh_in   <= in_byte;
            if (state == ST_RDATA) sh_out <= {sh_out[BYTE_W-2:0], 1'b0};
            if (byte_done) begin
                unique case (state)
                    ST_ADDR: begin
                        tgt  <= dec;
                        left <= tgt_len(dec);
                        if (dec == TGT_STATUS) begin
                            sh_out <= stat_byte;
                        end else if (dec == TGT_RXTONE) begin
                            sh_out <= rx_tone_word[WORD_W-1:BYTE_W];
                            rd_lo  <= rx_tone_word[BYTE_W-1:0];
                        end
                    end
                    ST_WDATA: begin
                        hi_byte <= in_byte;
                        left    <= left - 1'b1;
                    end
                    ST_RDATA: begin
                        sh_out <= rd_lo;
                        left   <= left - 1'b1;
                    end
                    ST_IDLE, ST_DISCARD: ;
                endcase
            end
        end
    end

    // ---------------- status and word registers ----------------
    tbs_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt_vec),
        .rd_clr     (rd_clr),
        .clr_notone (clr_notone),
        .clr_timer  (clr_timer),
        .wipe       (wipe),
        .flags      (flags)
    );

    tbs_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .wr_tgt      (tgt),
        .wr_data     (wr_data),
        .wipe        (wipe),
        .ctrl_reg    (ctrl_reg),
        .notone_word (notone_word),
        .timer_word  (timer_word),
        .tone1_word  (tone1_word),
        .tone2_word  (tone2_word),
        .notone_wr   (notone_wr),
        .timer_wr    (timer_wr),
        .tone1_wr    (tone1_wr),
        .tone2_wr    (tone2_wr),
        .gen_rst     (gen_rst)
    );

    assign irq_pull = (ctrl_reg[6] & flags[2]) | (ctrl_reg[5] & (flags[0] | flags[1]));

endmodule

// File: rtl/tone_bus_slave_chk.sv
module tone_bus_slave_chk #(
    parameter int SYNC_DEPTH = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_n,
    input logic        reply_en,
    input logic        irq_pull,
    input logic [7:0]  ctrl_reg,
    input logic [15:0] tone1_word,
    input logic [15:0] tone2_word,
    input logic        notone_wr,
    input logic        timer_wr,
    input logic        tone1_wr,
    input logic        tone2_wr,
    input logic        gen_rst,
    input logic        rd_clr,
    input logic [2:0]  evt_vec,
    input logic [2:0]  flags
);

    localparam int CW = $clog2(SYNC_DEPTH + 3);
    localparam logic [CW-1:0] CS_LIM = CW'(SYNC_DEPTH + 1);

    logic [CW-1:0] cs_hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       cs_hi_cnt <= '0;
        else if (!cs_n)                   cs_hi_cnt <= '0;
        else if (cs_hi_cnt != CS_LIM)     cs_hi_cnt <= cs_hi_cnt + 1'b1;
    end

    assert_reply_off_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_hi_cnt == CS_LIM) |-> !reply_en);

    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({notone_wr, timer_wr, tone1_wr, tone2_wr, gen_rst}));

    assert_tone1_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tone1_wr && !gen_rst) |=> ((!tone1_wr && !gen_rst) -> $stable(tone1_word)));

    assert_tone2_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tone2_wr && !gen_rst) |=> ((!tone2_wr && !gen_rst) -> $stable(tone2_word)));

    assert_ctrl_low_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_reg[7]) |-> (ctrl_reg[1:0] == 2'b00));

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && evt_vec == 3'b000) |=> (flags == 3'b000));

    assert_read_keeps_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && evt_vec[0]) |=> flags[0]);

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_reg[6:5] == 2'b00) |-> !irq_pull);

    assert_reset_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        gen_rst |-> (ctrl_reg == 8'h00 && tone1_word == 16'h0 && tone2_word == 16'h0 && !irq_pull));

endmodule

bind tone_bus_slave tone_bus_slave_chk #(.SYNC_DEPTH(SYNC_DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .reply_en   (reply_en),
    .irq_pull   (irq_pull),
    .ctrl_reg   (ctrl_reg),
    .tone1_word (tone1_word),
    .tone2_word (tone2_word),
    .notone_wr  (notone_wr),
    .timer_wr   (timer_wr),
    .tone1_wr   (tone1_wr),
    .tone2_wr   (tone2_wr),
    .gen_rst    (gen_rst),
    .rd_clr     (rd_clr),
    .evt_vec    (evt_vec),
    .flags      (flags)
);

// File: tb/tone_bus_slave_bench.sv
`timescale 1ns/1ps
module tone_bus_slave_bench;

    localparam int SYNC_DEPTH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        cmd_in = 1'b0;
    logic        logic_in = 1'b0;
    logic        meas_done_evt = 1'b0;
    logic        notone_evt = 1'b0;
    logic        timer_evt = 1'b0;
    logic [15:0] rx_tone_word = 16'h0;
    logic        reply_out, reply_en, irq_pull;
    logic [7:0]  ctrl_reg, notone_word, timer_word;
    logic [15:0] tone1_word, tone2_word;
    logic        notone_wr, timer_wr, tone1_wr, tone2_wr, gen_rst;

    always #2 clk = ~clk;

    tone_bus_slave #(.SYNC_DEPTH(SYNC_DEPTH)) u_tone_bus_slave (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .cmd_in(cmd_in),
        .reply_out(reply_out), .reply_en(reply_en), .irq_pull(irq_pull),
        .logic_in(logic_in), .meas_done_evt(meas_done_evt), .notone_evt(notone_evt),
        .timer_evt(timer_evt), .rx_tone_word(rx_tone_word), .ctrl_reg(ctrl_reg),
        .notone_word(notone_word), .timer_word(timer_word), .tone1_word(tone1_word),
        .tone2_word(tone2_word), .notone_wr(notone_wr), .timer_wr(timer_wr),
        .tone1_wr(tone1_wr), .tone2_wr(tone2_wr), .gen_rst(gen_rst)
    );

    // ---------------- counters and behavioural model ----------------
    int n_chk = 0, n_fail = 0;
    bit chk_en = 1'b0, done = 1'b0;
    logic [7:0]  m_ctrl = 0, m_not = 0, m_tim = 0;
    logic [15:0] m_t1 = 0, m_t2 = 0;
    logic [2:0]  m_fl = 0;
    logic        m_rd = 0;
    int c_t1 = 0, c_t2 = 0, c_not = 0, c_tim = 0, c_rst = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic m_irq();
        return (m_ctrl[6] & m_fl[2]) | (m_ctrl[5] & (m_fl[0] | m_fl[1]));
    endfunction

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && chk_en && !done) begin
            check("R3 ctrl_reg",   ctrl_reg,    m_ctrl);
            check("R2 notone",     notone_word, m_not);
            check("R2 timer",      timer_word,  m_tim);
            check("R2 tone1",      tone1_word,  m_t1);
            check("R2 tone2",      tone2_word,  m_t2);
            check("R9 irq_pull",   irq_pull,    m_irq());
            check("R6 reply_en",   reply_en,    m_rd);
        end
        if (rst_n) begin
            if (tone1_wr)  c_t1++;
            if (tone2_wr)  c_t2++;
            if (notone_wr) c_not++;
            if (timer_wr)  c_tim++;
            if (gen_rst)   c_rst++;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // shifts nb bits of tx (MSB first); last-bit events fire in the action cycle
    task automatic shift_byte(input logic [7:0] tx, input int nb, input logic [2:0] ev,
                              output logic [7:0] rx);
        rx = 8'h00;
        sclk = 1'b0;
        tick(); tick();
        for (int i = 7; i > 7 - nb; i--) begin
            cmd_in = tx[i];
            tick(); tick();
            rx[i] = reply_out;
            if (i == 0) chk_en = 1'b0;
            sclk = 1'b1;
            if (i == 0 && ev != 3'b000) begin
                repeat (SYNC_DEPTH) tick();
                {timer_evt, notone_evt, meas_done_evt} = ev;
                tick();
                {timer_evt, notone_evt, meas_done_evt} = 3'b000;
                repeat (3 - SYNC_DEPTH) tick();
            end else begin
                repeat (4) tick();
            end
            if (i != 0) begin
                sclk = 1'b0;
                tick(); tick();
            end
        end
    endtask

    task automatic cs_begin();
        cs_n = 1'b0;
        repeat (3) tick();
    endtask

    task automatic cs_end();
        sclk = 1'b0;
        tick(); tick();
        chk_en = 1'b0;
        cs_n = 1'b1;
        repeat (SYNC_DEPTH + 2) tick();
        m_rd = 1'b0;
        chk_en = 1'b1;
    endtask

    task automatic apply_write(input logic [7:0] ac, input logic [15:0] d);
        case (ac)
            8'h30: m_ctrl = {d[7:2], 2'b00};
            8'h33: begin m_not = d[7:0]; m_fl[1] = 1'b0; end
            8'h36: begin m_tim = d[7:0]; m_fl[2] = 1'b0; end
            8'h34: m_t1 = d;
            8'h35: m_t2 = d;
            default: ;
        endcase
    endtask

    task automatic write1(input logic [7:0] ac, input logic [7:0] d);
        logic [7:0] r;
        cs_begin();
        shift_byte(ac, 8, 3'b000, r); chk_en = 1'b1;
        shift_byte(d, 8, 3'b000, r);
        apply_write(ac, {8'h00, d}); chk_en = 1'b1;
        cs_end();
    endtask

    task automatic write2(input logic [7:0] ac, input logic [15:0] d);
        logic [7:0] r;
        cs_begin();
        shift_byte(ac, 8, 3'b000, r); chk_en = 1'b1;
        shift_byte(d[15:8], 8, 3'b000, r); chk_en = 1'b1;
        shift_byte(d[7:0], 8, 3'b000, r);
        apply_write(ac, d); chk_en = 1'b1;
        cs_end();
    endtask

    task automatic pulse_ev(input logic [2:0] ev);
        chk_en = 1'b0;
        {timer_evt, notone_evt, meas_done_evt} = ev;
        tick();
        {timer_evt, notone_evt, meas_done_evt} = 3'b000;
        m_fl = m_fl | ev;
        tick();
        chk_en = 1'b1;
    endtask

    task automatic read_status(input logic [2:0] ev, input string tag);
        logic [7:0] r, cap;
        cs_begin();
        shift_byte(8'h31, 8, ev, r);
        cap = {4'b0000, logic_in, m_fl};
        m_fl = ev;
        m_rd = 1'b1;
        chk_en = 1'b1;
        shift_byte(8'h00, 8, 3'b000, r);
        m_rd = 1'b0;
        chk_en = 1'b1;
        check(tag, r, cap);
        cs_end();
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [7:0] r, rh, rl;
        int k1, k2;
        repeat (5) tick();
        rst_n = 1'b1;
        repeat (3) tick();
        // reset state
        check("R10 reset ctrl", ctrl_reg, 8'h00);
        check("R6 reset reply_en", reply_en, 1'b0);
        check("R9 reset irq", irq_pull, 1'b0);
        chk_en = 1'b1;

        // R3: low control bits forced to zero
        write1(8'h30, 8'hFF);
        check("R3 ctrl FF", ctrl_reg, 8'hFC);

        // R2: one- and two-byte writes with strobes
        k1 = c_t1;
        write2(8'h34, 16'h1234);
        check("R2 tone1 value", tone1_word, 16'h1234);
        check("R2 tone1 strobe count", c_t1 - k1, 1);
        write2(8'h35, 16'hABCD);
        check("R2 tone2 value", tone2_word, 16'hABCD);
        write1(8'h33, 8'h5A);
        write1(8'h36, 8'h3C);
        check("R2 notone strobe", c_not, 1);
        check("R2 timer strobe", c_tim, 1);

        // R9 / R7: events set flags, interrupt by enables
        write1(8'h30, 8'h40);
        pulse_ev(3'b001);
        check("R9 decoder disabled irq", irq_pull, 1'b0);
        pulse_ev(3'b100);
        check("R9 timer enabled irq", irq_pull, 1'b1);

        // R4 / R7: status read with coincident event
        logic_in = 1'b1;
        repeat (4) tick();
        read_status(3'b001, "R4 status byte");
        check("R7 irq released", irq_pull, 1'b0);
        read_status(3'b000, "R7 event kept across clear");

        // R8: notone write clears bit 1, timer write clears bit 2
        write1(8'h30, 8'h20);
        pulse_ev(3'b110);
        check("R9 decoder irq from notone", irq_pull, 1'b1);
        write1(8'h33, 8'h11);
        logic_in = 1'b0;
        repeat (4) tick();
        read_status(3'b000, "R8 notone cleared");
        pulse_ev(3'b100);
        write1(8'h36, 8'h22);
        read_status(3'b000, "R8 timer cleared");

        // R5 / R6: two-byte reply captured at command time
        rx_tone_word = 16'hBEEF;
        cs_begin();
        shift_byte(8'h32, 8, 3'b000, r);
        m_rd = 1'b1; chk_en = 1'b1;
        rx_tone_word = 16'h0000;
        shift_byte(8'h00, 8, 3'b000, rh); chk_en = 1'b1;
        shift_byte(8'h00, 8, 3'b000, rl);
        m_rd = 1'b0; chk_en = 1'b1;
        check("R5 tone reply high", rh, 8'hBE);
        check("R5 tone reply low", rl, 8'hEF);
        shift_byte(8'h00, 8, 3'b000, r); chk_en = 1'b1;
        check("R6 no reply past end", reply_en, 1'b0);
        cs_end();

        // R11: unrecognised command and bytes past the end
        cs_begin();
        shift_byte(8'h37, 8, 3'b000, r); chk_en = 1'b1;
        shift_byte(8'hFF, 8, 3'b000, r); chk_en = 1'b1;
        shift_byte(8'h30, 8, 3'b000, r); chk_en = 1'b1;
        shift_byte(8'hFF, 8, 3'b000, r); chk_en = 1'b1;
        cs_end();
        check("R11 unknown ignored", ctrl_reg, 8'h20);
        cs_begin();
        shift_byte(8'h30, 8, 3'b000, r); chk_en = 1'b1;
        shift_byte(8'h10, 8, 3'b000, r); apply_write(8'h30, 16'h0010); chk_en = 1'b1;
        shift_byte(8'hE0, 8, 3'b000, r); chk_en = 1'b1;
        cs_end();
        check("R11 extra byte ignored", ctrl_reg, 8'h10);

        // R12: abort between bytes and mid-byte
        k1 = c_t1;
        cs_begin();
        shift_byte(8'h34, 8, 3'b000, r); chk_en = 1'b1;
        shift_byte(8'h77, 8, 3'b000, r); chk_en = 1'b1;
        cs_end();
        check("R12 partial word kept", tone1_word, 16'h1234);
        check("R12 no strobe", c_t1 - k1, 0);
        cs_begin();
        shift_byte(8'h30, 4, 3'b000, r);
        cs_end();
        write1(8'h30, 8'h84);
        check("R12 fresh decode", ctrl_reg, 8'h84);
        check("R1 msb first", ctrl_reg[7], 1'b1);

        // R10: general reset
        pulse_ev(3'b111);
        k2 = c_rst;
        cs_begin();
        shift_byte(8'h01, 8, 3'b000, r);
        m_ctrl = 0; m_not = 0; m_tim = 0; m_t1 = 0; m_t2 = 0; m_fl = 0;
        chk_en = 1'b1;
        cs_end();
        check("R10 gen_rst pulse", c_rst - k2, 1);
        check("R10 tone2 zero", tone2_word, 16'h0);
        read_status(3'b000, "R10 flags zero");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule